// File: doc/BRIEF.md
# Debug Trace/Return Sequencer

This block is the control sequencer of a small CPU's in-circuit debug engine. The CPU can enter debug mode in two ways: the host issues a break-in command, or a breakpoint comparator reports a match. On entry the sequencer stops the CPU and saves the current instruction pointer on the stack. It also saves the interrupt-enable and memory-access flags, then vectors the CPU to the fixed debug address 8010h, halts it and reports idle. From idle the host can send two commands. A single-step command lets the CPU execute exactly one instruction from the stacked return address, then forces re-entry into debug mode. A resume command leaves debug mode and hands the CPU back to the user program.

The CPU datapath, the stack memory, the breakpoint comparators and the host link are outside the block. They appear only as request/acknowledge lines, level controls and flag strobes. The sequencer also freezes the internal timers while debug mode is active. When switchback is enabled, it asks the clock divider to leave the slow power-saving clock when debug mode is entered.

Top module: `dbg_trace_seq`

## Requirements
- R1: After reset the status is 00, `cpu_run` is 1, `cpu_halt` and `timer_freeze` are 0 and no stack request is active.
- R2: The status reports 00 in normal execution, 01 when halted in debug mode, 10 while a sequence runs, and never 11.
- R3: A break-in (host op 11, or `bkpt_match` when not suppressed) does the following in order: capture `irq_en_cur` as the interrupt shadow, stall and block fetch, push `cpu_pc`, save and clear the memory-access flag, load IP with 8010h while clearing the interrupt enable, halt, and report 01.
- R4: A step (host op 01, accepted only at status 01) runs in this order: pop, load IP with the popped address, execute one instruction (`cpu_run` until `insn_done`), stall with fetch blocked, push, save and clear the memory-access flag, load IP with 8010h and clear the interrupt enable, halt, and report 01.
- R5: After a step, the address pushed is the `cpu_pc` that the CPU reports after its single instruction, i.e. the incremented address, not the popped one.
- R6: If the popped step address lies in the system region 8000h..9FFFh inclusive while `multi_region` is 1, the step is refused. In that case no IP load and no instruction run happen, the popped address is pushed back unchanged, and the status returns to 01.
- R7: A resume (host op 10, accepted only at status 01) runs in this order: pop, restore the saved memory-access flag on `macc_restore`/`macc_val`, load IP with the popped address, then status 00 with `cpu_run` high.
- R8: `timer_freeze` is 1 whenever the status is not 00 and returns to 0 when a resume completes.
- R9: `clk_switchback` pulses in the entry cycle exactly when `swb_en` and `pmm_active` are both 1.
- R10: Commands arriving while status is 10 are ignored. Step and resume are ignored while status is 00. An idle sequencer stays idle without a command.
- R11: A breakpoint match does not cause entry before the first `insn_done` after a resume. A match held past that instruction causes entry on the cycle after it.
- R12: Each push or pop request is held until `stk_ack`, and the sequence advances only on the acknowledge. Push and pop are never requested together.
- R13: The step and the resume both pulse `irq_en_set` with the IP load exactly when the shadow captured at the last break-in is 1. Steps do not change the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 01 step, 10 resume, 11 break-in |
| status | output | 2 | 00 normal, 01 debug idle, 10 busy |
| bkpt_match | input | 1 | Breakpoint comparator hit |
| swb_en | input | 1 | Switchback enable |
| pmm_active | input | 1 | Slow power-saving clock in use |
| clk_switchback | output | 1 | Request for divide-by-1 clock |
| multi_region | input | 1 | Several memory regions configured |
| stk_push_req | output | 1 | Stack push request |
| stk_pop_req | output | 1 | Stack pop request |
| stk_wdata | output | AW | Address to push |
| stk_rdata | input | AW | Popped address, valid with ack |
| stk_ack | input | 1 | Stack acknowledge |
| cpu_pc | input | AW | Current instruction pointer |
| insn_done | input | 1 | CPU finished an instruction |
| cpu_run | output | 1 | CPU may execute |
| cpu_stall | output | 1 | Hold CPU at instruction end |
| fetch_block | output | 1 | Block program fetch |
| cpu_halt | output | 1 | CPU halted in debug |
| ip_load | output | 1 | Load instruction pointer |
| ip_value | output | AW | Value for IP load |
| irq_en_cur | input | 1 | Current global interrupt enable |
| irq_en_set | output | 1 | Set global interrupt enable |
| irq_en_clr | output | 1 | Clear global interrupt enable |
| macc_cur | input | 1 | Current memory-access flag |
| macc_clr | output | 1 | Clear memory-access flag |
| macc_restore | output | 1 | Write saved flag back |
| macc_val | output | 1 | Saved memory-access flag |
| timer_freeze | output | 1 | Stop internal timers |

## Verification
The bench targets refusal at the edges of the system region (8000h, 9FFFh and their outer neighbours). A faulty boundary compare would either step into forbidden memory or wrongly refuse a legal address, and the pushed address would then show it. Commands are injected in the middle of a sequence, and stack acknowledges are given random delays. A sequencer that took those commands or skipped the handshake would pop twice or unbalance the stack. A breakpoint is held high from the moment a resume completes. A design that broke immediately, or never broke at all, misses the entry exactly one cycle after the first instruction. Random interrupt and memory-flag values make a stale shadow or an overwritten saved flag visible at the next step or resume.

// File: rtl/dbg_seq_pkg.sv
// Shared types for the debug trace/return sequencer.
package dbg_seq_pkg;

    // Host command codes carried on cmd_op.
    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_STEP   = 2'b01,
        OP_RESUME = 2'b10,
        OP_BREAK  = 2'b11
    } host_op_e;

    // Status codes reported to the host.
    localparam logic [1:0] STAT_NORMAL = 2'b00;
    localparam logic [1:0] STAT_IDLE   = 2'b01;
    localparam logic [1:0] STAT_BUSY   = 2'b10;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_NORM,   // user program runs
        S_IDLE,   // halted in debug, waiting for host
        S_POP,    // step: pop return address
        S_CHK,    // step: region check on popped address
        S_FEED,   // step: load IP, restore interrupt enable
        S_EXEC,   // step: one instruction executes
        S_BLOCK,  // stall, fetch blocked
        S_PUSH,   // push return address
        S_FLAG,   // save and clear memory-access flag
        S_VEC,    // load debug vector, clear interrupt enable
        S_HALT,   // halt CPU
        S_RPOP,   // resume: pop return address
        S_RFLAG,  // resume: restore memory-access flag
        S_RFEED   // resume: load IP, restore interrupt enable
    } seq_state_e;

endpackage

// File: rtl/dbg_seq_fsm.sv
// Sequencer state register and next-state logic.
// Assumes stk_ack is a single-cycle pulse answering an active request and
// insn_done pulses once per completed instruction.
module dbg_seq_fsm
    import dbg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       enter_req,
    input  logic       stk_ack,
    input  logic       refuse,
    input  logic       insn_done,
    output seq_state_e state,
    output logic       redo
);

    seq_state_e nxt;
    logic       redo_nxt;

    // Next-state selection for break-in, step and resume sequences.
    always_comb begin
        nxt      = state;
        redo_nxt = redo;
        case (state)
            S_NORM:  if (enter_req) begin
                         nxt      = S_BLOCK;
                         redo_nxt = 1'b0;
                     end
            S_IDLE:  if (cmd_valid && cmd_op == OP_STEP)   nxt = S_POP;
                     else if (cmd_valid && cmd_op == OP_RESUME) nxt = S_RPOP;
            S_POP:   if (stk_ack) nxt = S_CHK;
            S_CHK:   begin
                         redo_nxt = refuse;
                         nxt      = refuse ? S_PUSH : S_FEED;
                     end
            S_FEED:  nxt = S_EXEC;
            S_EXEC:  if (insn_done) nxt = S_BLOCK;
            S_BLOCK: begin
                         redo_nxt = 1'b0;
                         nxt      = S_PUSH;
                     end
            S_PUSH:  if (stk_ack) nxt = redo ? S_IDLE : S_FLAG;
            S_FLAG:  nxt = S_VEC;
            S_VEC:   nxt = S_HALT;
            S_HALT:  nxt = S_IDLE;
            S_RPOP:  if (stk_ack) nxt = S_RFLAG;
            S_RFLAG: nxt = S_RFEED;
            S_RFEED: nxt = S_NORM;
            default: nxt = S_NORM;
        endcase
    end

    // State and refusal flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_NORM;
            redo  <= 1'b0;
        end else begin
            state <= nxt;
            redo  <= redo_nxt;
        end
    end

endmodule

// File: rtl/dbg_seq_ctx.sv
// Context kept across debug mode: popped return address, interrupt-enable
// shadow taken at break-in, saved memory-access flag, and the region check
// that refuses a step into system memory.
// Assumes stk_rdata is valid in the cycle stk_ack is high.
module dbg_seq_ctx
    import dbg_seq_pkg::*;
#(
    parameter int              AW       = 16,
    parameter logic [AW-1:0]   SYS_BASE = 16'h8000,
    parameter logic [AW-1:0]   SYS_LAST = 16'h9FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_e    state,
    input  logic          enter_req,
    input  logic          stk_ack,
    input  logic [AW-1:0] stk_rdata,
    input  logic          irq_en_cur,
    input  logic          macc_cur,
    input  logic          multi_region,
    output logic [AW-1:0] ret_addr,
    output logic          irq_shadow,
    output logic          macc_saved,
    output logic          refuse
);

    logic pop_done;
    logic in_sys;

    assign pop_done = stk_ack && (state == S_POP || state == S_RPOP);
    assign in_sys   = (ret_addr >= SYS_BASE) && (ret_addr <= SYS_LAST);
    assign refuse   = multi_region && in_sys;

    // Capture return address, interrupt shadow and memory-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr   <= '0;
            irq_shadow <= 1'b0;
            macc_saved <= 1'b0;
        end else begin
            if (pop_done)
                ret_addr <= stk_rdata;
            if (state == S_NORM && enter_req)
                irq_shadow <= irq_en_cur;
            if (state == S_FLAG)
                macc_saved <= macc_cur;
        end
    end

endmodule

// File: rtl/dbg_seq_brk.sv
// Break-in request and clock switchback. Suppresses a breakpoint hit until
// the first instruction after a resume has completed.
// Assumes bkpt_match is qualified by the comparators for the current fetch.
module dbg_seq_brk
    import dbg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       bkpt_match,
    input  logic       insn_done,
    input  logic       swb_en,
    input  logic       pmm_active,
    output logic       enter_req,
    output logic       clk_switchback
);

    logic sup_q;

    assign enter_req = (state == S_NORM) &&
                       ((cmd_valid && cmd_op == OP_BREAK) || (bkpt_match && !sup_q));
    assign clk_switchback = enter_req && swb_en && pmm_active;

    // Suppression flag: armed by resume, dropped after the first instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sup_q <= 1'b0;
        else if (state == S_RFEED)
            sup_q <= 1'b1;
        else if (state != S_NORM || insn_done)
            sup_q <= 1'b0;
    end

endmodule

// File: rtl/dbg_trace_seq.sv
// Top of the debug trace/return sequencer: ties the state machine, context
// store and break-in logic together and decodes the CPU, stack and flag
// controls from the current state.
// Assumes the CPU holds cpu_pc stable while cpu_run is low.
module dbg_trace_seq
    import dbg_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] DBG_VEC  = 16'h8010,
    parameter logic [AW-1:0] SYS_BASE = 16'h8000,
    parameter logic [AW-1:0] SYS_LAST = 16'h9FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    output logic [1:0]    status,
    input  logic          bkpt_match,
    input  logic          swb_en,
    input  logic          pmm_active,
    output logic          clk_switchback,
    input  logic          multi_region,
    output logic          stk_push_req,
    output logic          stk_pop_req,
    output logic [AW-1:0] stk_wdata,
    input  logic [AW-1:0] stk_rdata,
    input  logic          stk_ack,
    input  logic [AW-1:0] cpu_pc,
    input  logic          insn_done,
    output logic          cpu_run,
    output logic          cpu_stall,
    output logic          fetch_block,
    output logic          cpu_halt,
    output logic          ip_load,
    output logic [AW-1:0] ip_value,
    input  logic          irq_en_cur,
    output logic          irq_en_set,
    output logic          irq_en_clr,
    input  logic          macc_cur,
    output logic          macc_clr,
    output logic          macc_restore,
    output logic          macc_val,
    output logic          timer_freeze
);

    seq_state_e    state;
    logic          redo;
    logic          enter_req;
    logic          refuse;
    logic [AW-1:0] ret_addr;
    logic          irq_shadow;
    logic          macc_saved;

    dbg_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .enter_req (enter_req),
        .stk_ack   (stk_ack),
        .refuse    (refuse),
        .insn_done (insn_done),
        .state     (state),
        .redo      (redo)
    );

    dbg_seq_ctx #(
        .AW       (AW),
        .SYS_BASE (SYS_BASE),
        .SYS_LAST (SYS_LAST)
    ) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .enter_req    (enter_req),
        .stk_ack      (stk_ack),
        .stk_rdata    (stk_rdata),
        .irq_en_cur   (irq_en_cur),
        .macc_cur     (macc_cur),
        .multi_region (multi_region),
        .ret_addr     (ret_addr),
        .irq_shadow   (irq_shadow),
        .macc_saved   (macc_saved),
        .refuse       (refuse)
    );

    dbg_seq_brk u_brk (
        .clk            (clk),
        .rst_n          (rst_n),
        .state          (state),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .bkpt_match     (bkpt_match),
        .insn_done      (insn_done),
        .swb_en         (swb_en),
        .pmm_active     (pmm_active),
        .enter_req      (enter_req),
        .clk_switchback (clk_switchback)
    );

    // Status code from state.
    always_comb begin
        if (state == S_NORM)      status = STAT_NORMAL;
        else if (state == S_IDLE) status = STAT_IDLE;
        else                      status = STAT_BUSY;
    end

    // CPU, stack, IP and flag controls from state.
    always_comb begin
        cpu_run      = (state == S_NORM) || (state == S_EXEC);
        cpu_stall    = (state == S_BLOCK) || (state == S_PUSH) ||
                       (state == S_FLAG) || (state == S_VEC);
        fetch_block  = cpu_stall;
        cpu_halt     = (state == S_HALT) || (state == S_IDLE) || (state == S_POP) ||
                       (state == S_CHK) || (state == S_RPOP) || (state == S_RFLAG);
        stk_pop_req  = (state == S_POP) || (state == S_RPOP);
        stk_push_req = (state == S_PUSH);
        stk_wdata    = redo ? ret_addr : cpu_pc;
        ip_load      = (state == S_FEED) || (state == S_RFEED) || (state == S_VEC);
        ip_value     = (state == S_VEC) ? DBG_VEC : ret_addr;
        irq_en_set   = ((state == S_FEED) || (state == S_RFEED)) && irq_shadow;
        irq_en_clr   = (state == S_VEC);
        macc_clr     = (state == S_FLAG);
        macc_restore = (state == S_RFLAG);
        macc_val     = macc_saved;
        timer_freeze = (state != S_NORM);
    end

endmodule

// File: rtl/dbg_trace_seq_chk.sv
// Protocol checker for the debug sequencer, attached by bind.
module dbg_trace_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    status,
    input logic          stk_push_req,
    input logic          stk_pop_req,
    input logic          stk_ack,
    input logic          cpu_run,
    input logic          fetch_block,
    input logic          cpu_halt,
    input logic          ip_load,
    input logic [AW-1:0] ip_value,
    input logic          clk_switchback,
    input logic          swb_en,
    input logic          pmm_active,
    input logic          timer_freeze
);

    a_r2_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    a_r12_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop_req && !stk_ack |=> stk_pop_req);

    a_r12_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push_req && !stk_ack |=> stk_push_req);

    a_r12_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push_req && stk_pop_req));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b01 && !cmd_valid |=> status == 2'b01);

    a_r9_switchback: assert property (@(posedge clk) disable iff (!rst_n)
        clk_switchback |-> swb_en && pmm_active && status == 2'b00);

    a_r4_run_free: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> !fetch_block && !cpu_halt);

    a_r7_resume_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timer_freeze) |-> $past(ip_load) && $past(status) == 2'b10);

endmodule

bind dbg_trace_seq dbg_trace_seq_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .status         (status),
    .stk_push_req   (stk_push_req),
    .stk_pop_req    (stk_pop_req),
    .stk_ack        (stk_ack),
    .cpu_run        (cpu_run),
    .fetch_block    (fetch_block),
    .cpu_halt       (cpu_halt),
    .ip_load        (ip_load),
    .ip_value       (ip_value),
    .clk_switchback (clk_switchback),
    .swb_en         (swb_en),
    .pmm_active     (pmm_active),
    .timer_freeze   (timer_freeze)
);

// File: tb/dbg_trace_seq_bench.sv
module dbg_trace_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [1:0]  status;
    logic        bkpt_match = 1'b0, swb_en = 1'b0, pmm_active = 1'b0;
    logic        clk_switchback, multi_region = 1'b0;
    logic        stk_push_req, stk_pop_req, stk_ack = 1'b0;
    logic [15:0] stk_wdata, stk_rdata = 16'h0, cpu_pc = 16'h0100, ip_value;
    logic        insn_done = 1'b0;
    logic        cpu_run, cpu_stall, fetch_block, cpu_halt, ip_load;
    logic        irq_en_cur = 1'b0, irq_en_set, irq_en_clr;
    logic        macc_cur = 1'b0, macc_clr, macc_restore, macc_val, timer_freeze;

    always #10 clk = ~clk;   // 50 MHz

    dbg_trace_seq u_dbg_trace_seq (.*);

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] stk [0:15];
    int sp = 0, swait = 0, icnt = 1;

    // Stack model with random acknowledge delay.
    always @(negedge clk) begin
        if (!rst_n) begin
            stk_ack = 1'b0; sp = 0; swait = 0;
        end else if (stk_ack) stk_ack = 1'b0;
        else if (stk_pop_req || stk_push_req) begin
            if (swait > 0) swait--;
            else begin
                stk_ack = 1'b1;
                if (stk_pop_req) begin sp--; stk_rdata = stk[sp]; end
                else begin stk[sp] = stk_wdata; sp++; end
                swait = $urandom % 3;
            end
        end
    end

    // CPU model: IP load, instruction completion with increment.
    always @(negedge clk) begin
        insn_done = 1'b0;
        if (rst_n) begin
            if (ip_load) begin cpu_pc = ip_value; icnt = 1 + $urandom % 3; end
            else if (cpu_run) begin
                if (icnt <= 1) begin
                    insn_done = 1'b1; cpu_pc = cpu_pc + 16'd1; icnt = 1 + $urandom % 3;
                end else icnt--;
            end
        end
    end

    // Event log.
    int c_pop, c_push, c_feed, c_done, c_uclr, c_vec, c_rest;
    int n_pop, n_push, n_feed, n_vec, n_rest, n_swb, n_iclr, n_done, n_runx;
    logic [15:0] push_val, feed_val;
    logic feed_irq, rest_val;

    task automatic clear_log();
        c_pop = -1; c_push = -1; c_feed = -1; c_done = -1; c_uclr = -1; c_vec = -1; c_rest = -1;
        n_pop = 0; n_push = 0; n_feed = 0; n_vec = 0; n_rest = 0; n_swb = 0; n_iclr = 0;
        n_done = 0; n_runx = 0; feed_irq = 0; rest_val = 0;
    endtask

    always begin
        @(negedge clk); #8;
        cyc++;
        if (stk_pop_req && stk_ack) begin c_pop = cyc; n_pop++; end
        if (stk_push_req && stk_ack) begin c_push = cyc; n_push++; push_val = stk_wdata; end
        if (ip_load && irq_en_clr) begin c_vec = cyc; n_vec++; end
        else if (ip_load) begin c_feed = cyc; n_feed++; feed_val = ip_value; feed_irq = irq_en_set; end
        if (irq_en_clr) n_iclr++;
        if (insn_done && status == 2'b10) begin c_done = cyc; n_done++; end
        if (cpu_run && status != 2'b00) n_runx++;
        if (macc_clr) c_uclr = cyc;
        if (macc_restore) begin c_rest = cyc; n_rest++; rest_val = macc_val; end
        if (clk_switchback) n_swb++;
    end

    task automatic tick(); @(negedge clk); #5; endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_stat(input logic [1:0] s, input int lim, input string tag);
        int k = 0;
        while (status !== s && k < lim) begin tick(); k++; end
        if (status !== s) chk(0, tag, status, s);
    endtask

    function automatic bit f_refuse(input logic [15:0] a, input bit multi);
        return multi && a >= 16'h8000 && a <= 16'h9FFF;
    endfunction

    function automatic logic [15:0] f_next(input logic [15:0] a);
        return a + 16'd1;
    endfunction

    bit exp_shadow = 0, exp_macc = 0;

    task automatic do_entry(input bit via_bkpt, input bit after_resume);
        bit sw;
        logic [15:0] epc;
        int sp0 = sp;
        int k = 0;
        irq_en_cur = $urandom % 2; macc_cur = $urandom % 2;
        swb_en = $urandom % 2; pmm_active = $urandom % 2;
        sw = swb_en && pmm_active;
        clear_log();
        if (via_bkpt) begin
            bkpt_match = 1'b1;
            if (after_resume) begin
                while (!insn_done && k < 20) begin tick(); k++; end
                tick();
                chk(status == 2'b00, "R11 break suppressed on first instruction", status, 0);
                tick();
                chk(status == 2'b10, "R11 break after first instruction", status, 2);
            end else
                while (status == 2'b00 && k < 20) begin tick(); k++; end
            bkpt_match = 1'b0;
        end else begin
            cmd_valid = 1'b1; cmd_op = 2'b11;
            tick();
            cmd_valid = 1'b0;
        end
        epc = cpu_pc;
        exp_shadow = irq_en_cur; exp_macc = macc_cur;
        wait_stat(2'b01, 40, "R3 entry reaches idle");
        chk(push_val == epc && n_push == 1, "R3 entry pushes IP", push_val, epc);
        chk(n_vec == 1 && c_push < c_uclr && c_uclr < c_vec, "R3 entry order", c_vec, c_uclr);
        chk(cpu_halt == 1'b1 && n_iclr == 1, "R3 halted with irq cleared", cpu_halt, 1);
        chk(timer_freeze == 1'b1, "R8 timers frozen in debug", timer_freeze, 1);
        chk(n_swb == int'(sw), "R9 switchback pulse", n_swb, sw);
        chk(sp == sp0 + 1, "R12 stack depth after entry", sp, sp0 + 1);
    endtask

    task automatic do_step(input logic [15:0] a, input bit multi, input bit extra);
        bit rf = f_refuse(a, multi);
        int sp0 = sp;
        stk[sp - 1] = a; multi_region = multi; macc_cur = $urandom % 2;
        clear_log();
        cmd_valid = 1'b1; cmd_op = 2'b01;
        tick();
        cmd_valid = 1'b0;
        chk(status == 2'b10, "R2 busy during step", status, 2);
        if (extra) begin
            tick();
            cmd_valid = 1'b1; cmd_op = ($urandom % 2) ? 2'b01 : 2'b10;
            tick();
            cmd_valid = 1'b0;
        end
        wait_stat(2'b01, 60, "R4 step returns to idle");
        chk(n_pop == 1 && n_push == 1, "R10 one pop per step", n_pop, 1);
        chk(sp == sp0, "R12 stack balanced", sp, sp0);
        if (rf) begin
            chk(push_val == a, "R6 refused address pushed back", push_val, a);
            chk(n_feed == 0 && n_runx == 0 && n_vec == 0, "R6 no run when refused", n_runx, 0);
        end else begin
            chk(feed_val == a, "R4 IP loaded with popped address", feed_val, a);
            chk(push_val == f_next(a), "R5 incremented address pushed", push_val, f_next(a));
            chk(n_done == 1 && c_pop < c_feed && c_feed < c_done && c_done < c_push &&
                c_push < c_uclr && c_uclr < c_vec, "R4 step order", c_done, c_feed);
            chk(feed_irq == exp_shadow, "R13 step irq restore from shadow", feed_irq, exp_shadow);
            chk(n_iclr == 1 && cpu_halt == 1'b1, "R4 irq cleared and halted", n_iclr, 1);
            exp_macc = macc_cur;
        end
    endtask

    task automatic do_resume(input logic [15:0] a);
        int sp0 = sp;
        stk[sp - 1] = a;
        clear_log();
        cmd_valid = 1'b1; cmd_op = 2'b10;
        tick();
        cmd_valid = 1'b0;
        wait_stat(2'b00, 40, "R7 resume reaches normal");
        chk(n_pop == 1 && sp == sp0 - 1, "R12 resume pops once", n_pop, 1);
        chk(n_rest == 1 && rest_val == exp_macc, "R7 memory flag restored", rest_val, exp_macc);
        chk(feed_val == a && c_pop < c_rest && c_rest < c_feed, "R7 resume order and IP", feed_val, a);
        chk(feed_irq == exp_shadow, "R13 resume irq restore from shadow", feed_irq, exp_shadow);
        chk(timer_freeze == 1'b0 && cpu_run == 1'b1, "R8 timers resume", timer_freeze, 0);
    endtask

    function automatic logic [15:0] rand_addr();
        if ($urandom % 2) return 16'h8000 + 16'($urandom % 16'h2000);
        return 16'($urandom);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'd2024);
        clear_log();
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk(status == 2'b00 && cpu_run == 1'b1, "R1 reset state run", status, 0);
        chk(cpu_halt == 1'b0 && timer_freeze == 1'b0 && !stk_pop_req && !stk_push_req,
            "R1 reset controls", cpu_halt, 0);
        cmd_valid = 1'b1; cmd_op = 2'b01;
        tick();
        cmd_valid = 1'b0;
        tick(); tick();
        chk(status == 2'b00 && n_pop == 0, "R10 step ignored when not in debug", status, 0);
        do_entry(0, 0);
        do_step(16'h8000, 1, 0);
        do_step(16'h7FFF, 1, 0);
        do_step(16'h9FFF, 1, 1);
        do_step(16'hA000, 1, 0);
        do_step(16'h8010, 0, 1);
        do_resume(rand_addr());
        do_entry(1, 1);
        for (int i = 0; i < 30; i++) begin
            int ns = $urandom % 4;
            for (int j = 0; j < ns; j++)
                do_step(rand_addr(), $urandom % 2, $urandom % 2);
            do_resume(rand_addr());
            if (i % 2) do_entry(1, 1);
            else begin
                repeat (3) tick();
                do_entry(0, 0);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule